// File: doc/BRIEF.md
# Video Image Packet Length Repair

This block sits in a packet-based pixel stream that uses a valid/ready handshake and start and end markers. It watches for control packets and keeps the frame width and height they carry. It checks every image packet that follows against the pixel count those dimensions give. A short image packet has its premature end marker removed. The block then appends filler pixels of a fixed colour until the count is reached, and marks the final filler beat as the end. A long image packet is cut off: the end marker is forced onto the last expected pixel, and the surplus input beats are taken from upstream and thrown away. Downstream blocks that count pixels therefore always see frames of the advertised size.

The first beat of each packet states the packet type in its low four bits. Control packets, unknown packet types and stray beats are forwarded untouched, in the same cycle. Until a usable control packet has arrived, the block has no reference, so image packets also go through untouched. Two event counters record how many image packets had to be padded and how many had to be truncated.

Top module: `vid_len_fixer`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` follows `out_ready`, and both event counters read zero.
- R2: A control packet is recognised by a first beat (sop) whose low nibble is 0xF. It passes through unchanged and with no added latency. Its first eight payload beats supply, through their low nibbles and most significant nibble first, a 16-bit width followed by a 16-bit height. These dimensions take effect when the packet's end beat is accepted.
- R3: Before any control packet has set dimensions, image packets are forwarded beat for beat with their own markers. An image packet is one whose sop beat has a low nibble of 0x0.
- R4: An image packet whose pixel count (beats after the sop beat) equals width times height is forwarded unchanged.
- R5: When an image packet ends early, its end marker is removed from the output. The block then emits filler beats carrying the constant `FILL_PIXEL`, with sop low, until the expected count is reached, and only the last filler beat carries eop. `in_ready` is low while filler beats are offered.
- R6: When an image packet is too long, eop is forced onto the last expected pixel. The extra input beats up to and including the input's own end are accepted with `in_ready` high and produce no output.
- R7: When several control packets precede an image packet, only the most recent one sets its expected size.
- R8: A control packet with fewer than eight payload beats, or one that carries a zero width or zero height, leaves the stored dimensions unchanged.
- R9: Packets of any other type pass through unchanged and do not affect the event counters.
- R10: `pad_count` rises by one for each padded image packet and `trunc_count` by one for each truncated image packet.
- R11: All of the above holds when `out_ready` is deasserted at arbitrary times. A filler beat held by `out_ready` low keeps its value.
- R12: An image packet consisting only of its sop beat with eop set is padded to the full expected pixel count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Block can take the upstream beat |
| in_data | input | DATA_W | Upstream beat payload |
| in_sop | input | 1 | Upstream first beat of packet |
| in_eop | input | 1 | Upstream last beat of packet |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_data | output | DATA_W | Downstream beat payload |
| out_sop | output | 1 | Downstream first beat of packet |
| out_eop | output | 1 | Downstream last beat of packet |
| pad_count | output | STAT_W | Number of image packets padded |
| trunc_count | output | STAT_W | Number of image packets truncated |

## Verification
A corrupted pixel count or stored product shows up at the next repaired packet. The end marker lands on the wrong beat, or the number of filler beats or dropped beats is wrong, and the bench scoreboard detects this on the first beat that differs. A wrong packet-type state shows up in the first packet after the fault. The block then pads a control or unknown packet that should pass through, or forwards excess pixels, and the output stream drifts out of step with the expected queue within that one packet. Counter faults show at the next statistics comparison, which is made after every group of packets.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

   localparam logic [3:0] KIND_CTRL  = 4'hF;
   localparam logic [3:0] KIND_IMAGE = 4'h0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_IMG,
      ST_PAD,
      ST_DROP,
      ST_RAW
   } fix_state_e;

endpackage

// File: rtl/vlf_dim_capture.sv
module vlf_dim_capture #(
   parameter int DIM_W = 16,
   localparam int SH_W  = 2 * DIM_W,
   localparam int NIBS  = SH_W / 4,
   localparam int NC_W  = $clog2(NIBS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            take,
   input  logic [3:0]      nib,
   input  logic            last,
   output logic            dims_valid,
   output logic [SH_W-1:0] total
);

   logic [SH_W-1:0]  shadow_q, shadow_nx;
   logic [NC_W-1:0]  ncnt_q, ncnt_nx;
   logic [DIM_W-1:0] w_nx, h_nx;
   logic             commit;

   generate
      if (DIM_W % 4 != 0) begin : g_bad_dim
         $error("DIM_W must be a multiple of four");
      end
   endgenerate

   always_comb begin
      shadow_nx = shadow_q;
      ncnt_nx   = ncnt_q;
      if (ncnt_q < NC_W'(NIBS)) begin
         shadow_nx = {shadow_q[SH_W-5:0], nib};
         ncnt_nx   = ncnt_q + 1'b1;
      end
   end

   assign w_nx   = shadow_nx[SH_W-1:DIM_W];
   assign h_nx   = shadow_nx[DIM_W-1:0];
   assign commit = take && last && (ncnt_nx == NC_W'(NIBS)) &&
                   (w_nx != '0) && (h_nx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q   <= '0;
         ncnt_q     <= '0;
         dims_valid <= 1'b0;
         total      <= '0;
      end else begin
         if (start) begin
            ncnt_q <= '0;
         end else if (take) begin
            shadow_q <= shadow_nx;
            ncnt_q   <= ncnt_nx;
         end
         if (commit) begin
            dims_valid <= 1'b1;
            total      <= SH_W'(w_nx) * SH_W'(h_nx);
         end
      end
   end

   // once dimensions exist they are never forgotten (R7)
   assert_dims_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dims_valid |=> dims_valid);

   // an incomplete or zero-sized control packet keeps the old product (R8)
   assert_keep_dims_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last && !commit) |=> $stable(total));

endmodule

// File: rtl/vlf_pix_count.sv
module vlf_pix_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] total,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign last = (cnt_q == total - 1'b1);

   // the controller never advances past the final expected pixel (R6)
   assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !last);

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/vlf_event_ctr.sv
module vlf_event_ctr #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   generate
      if (W < 1) begin : g_bad_w
         $error("event counter width must be positive");
      end
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  count <= '0;
            else if (inc && count != '1) count <= count + 1'b1;
         end
         assert_sat_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && count != '1) |=> count == $past(count) + 1'b1);
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   count <= '0;
            else if (inc) count <= count + 1'b1;
         end
         assert_wrap_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
            inc |=> count == $past(count) + 1'b1);
      end
   endgenerate

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));

endmodule

// File: rtl/vid_len_fixer.sv
module vid_len_fixer
   import vlf_pkg::*;
#(
   parameter int               DATA_W    = 24,
   parameter int               DIM_W     = 16,
   parameter int               STAT_W    = 16,
   parameter bit               STAT_SAT  = 1'b0,
   parameter logic [DATA_W-1:0] FILL_PIXEL = DATA_W'(24'h108080),
   localparam int              CNT_W     = 2 * DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic [STAT_W-1:0] pad_count,
   output logic [STAT_W-1:0] trunc_count
);

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("DATA_W must hold a four-bit packet kind");
      end
   endgenerate

   fix_state_e       st_q, st_nx;
   logic             acc_in, acc_out;
   logic             hdr_ctrl, hdr_img;
   logic             dims_valid, pix_last;
   logic [CNT_W-1:0] total;
   logic             ctrl_start, ctrl_take;
   logic             pix_clr, pix_inc;
   logic             pad_inc, trunc_inc;

   assign acc_in   = in_valid && in_ready;
   assign acc_out  = out_valid && out_ready;
   assign hdr_ctrl = in_sop && (in_data[3:0] == KIND_CTRL);
   assign hdr_img  = in_sop && (in_data[3:0] == KIND_IMAGE);

   vlf_dim_capture #(.DIM_W(DIM_W)) u_dims (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ctrl_start),
      .take       (ctrl_take),
      .nib        (in_data[3:0]),
      .last       (in_eop),
      .dims_valid (dims_valid),
      .total      (total)
   );

   vlf_pix_count #(.CNT_W(CNT_W)) u_pix (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pix_clr),
      .inc   (pix_inc),
      .total (total),
      .last  (pix_last)
   );

   vlf_event_ctr #(.W(STAT_W), .SATURATE(STAT_SAT)) u_pad_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (pad_inc),
      .count (pad_count)
   );

   vlf_event_ctr #(.W(STAT_W), .SATURATE(STAT_SAT)) u_trunc_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (trunc_inc),
      .count (trunc_count)
   );

   // datapath selection
   always_comb begin
      out_valid = in_valid;
      out_data  = in_data;
      out_sop   = in_sop;
      out_eop   = in_eop;
      in_ready  = out_ready;
      unique case (st_q)
         ST_IDLE: begin
            if (hdr_img && dims_valid) out_eop = 1'b0;
         end
         ST_IMG: begin
            out_sop = 1'b0;
            out_eop = pix_last;
         end
         ST_PAD: begin
            out_valid = 1'b1;
            out_data  = FILL_PIXEL;
            out_sop   = 1'b0;
            out_eop   = pix_last;
            in_ready  = 1'b0;
         end
         ST_DROP: begin
            out_valid = 1'b0;
            out_sop   = 1'b0;
            out_eop   = 1'b0;
            in_ready  = 1'b1;
         end
         default: ;
      endcase
   end

   // packet sequencing
   always_comb begin
      st_nx      = st_q;
      ctrl_start = 1'b0;
      ctrl_take  = 1'b0;
      pix_clr    = 1'b0;
      pix_inc    = 1'b0;
      pad_inc    = 1'b0;
      trunc_inc  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (acc_in && in_sop) begin
               if (hdr_ctrl) begin
                  ctrl_start = 1'b1;
                  st_nx      = in_eop ? ST_IDLE : ST_CTRL;
               end else if (hdr_img && dims_valid) begin
                  pix_clr = 1'b1;
                  pad_inc = in_eop;
                  st_nx   = in_eop ? ST_PAD : ST_IMG;
               end else begin
                  st_nx = in_eop ? ST_IDLE : ST_RAW;
               end
            end
         end
         ST_CTRL: begin
            if (acc_in) begin
               ctrl_take = 1'b1;
               if (in_eop) st_nx = ST_IDLE;
            end
         end
         ST_IMG: begin
            if (acc_in) begin
               if (pix_last) begin
                  trunc_inc = !in_eop;
                  st_nx     = in_eop ? ST_IDLE : ST_DROP;
               end else begin
                  pix_inc = 1'b1;
                  if (in_eop) begin
                     pad_inc = 1'b1;
                     st_nx   = ST_PAD;
                  end
               end
            end
         end
         ST_PAD: begin
            if (acc_out) begin
               if (pix_last) st_nx = ST_IDLE;
               else          pix_inc = 1'b1;
            end
         end
         ST_DROP: begin
            if (acc_in && in_eop) st_nx = ST_IDLE;
         end
         ST_RAW: begin
            if (acc_in && in_eop) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nx;
   end

   // an end marker inside a repaired image lands only on the final expected pixel (R6)
   assert_eop_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_out && out_eop && (st_q == ST_IMG || st_q == ST_PAD)) |-> pix_last);

   // filler keeps flowing until the count is met, and upstream is held off (R5)
   assert_pad_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD && acc_out && !pix_last) |=> (st_q == ST_PAD && !in_ready));

   // a stalled filler beat is held steady (R11)
   assert_pad_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

   // surplus beats never reach the output (R6)
   assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IMG && acc_in && pix_last && !in_eop) |=> !out_valid);

endmodule

// File: tb/vid_len_fixer_tb.sv
`timescale 1ns/1ps
module vid_len_fixer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 24;
   localparam int SW         = 16;
   localparam logic [DW-1:0] FILL = 24'h108080;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          in_sop = 1'b0;
   logic          in_eop = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic          out_sop, out_eop;
   logic [SW-1:0] pad_count, trunc_count;

   typedef struct {
      logic [DW-1:0] d;
      logic          s;
      logic          e;
      int            r;
      bit            pad;
   } beat_t;

   beat_t sb[$];
   beat_t got;
   int    checks = 0;
   int    errors = 0;
   bit    bp_on = 1'b0;
   logic [7:0] lf = 8'hA5;

   bit    m_dv = 1'b0;
   int    m_tot = 0;
   int    m_pad = 0;
   int    m_trunc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_len_fixer #(.DATA_W(DW), .DIM_W(16), .STAT_W(SW), .FILL_PIXEL(FILL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop),
      .pad_count(pad_count), .trunc_count(trunc_count)
   );

   // downstream readiness pattern
   always @(negedge clk) begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready <= bp_on ? (lf[0] | lf[3]) : 1'b1;
   end

   // monitor: pops the scoreboard on every accepted output beat
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (rst_n && out_valid && out_ready) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R6 unexpected output beat actual data=%h sop=%b eop=%b expected none",
                        out_data, out_sop, out_eop);
            end else begin
               got = sb.pop_front();
               if (out_data !== got.d || out_sop !== got.s || out_eop !== got.e) begin
                  errors++;
                  $display("FAIL R%0d beat actual data=%h sop=%b eop=%b expected data=%h sop=%b eop=%b",
                           got.r, out_data, out_sop, out_eop, got.d, got.s, got.e);
               end
               if (got.pad) begin
                  checks++;
                  if (in_ready !== 1'b0) begin
                     errors++;
                     $display("FAIL R5 in_ready during filler actual=%b expected=0", in_ready);
                  end
               end
            end
         end
      end
   end

   task automatic push(input logic [DW-1:0] d, input logic s, input logic e,
                       input int r, input bit pad);
      beat_t b;
      b.d = d; b.s = s; b.e = e; b.r = r; b.pad = pad;
      sb.push_back(b);
   endtask

   task automatic drive_beat(input logic [DW-1:0] d, input logic s, input logic e);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      forever begin
         #(CLK_PERIOD/4);
         if (in_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2: control packet, nibbles of width then height, most significant first
   task automatic send_ctrl(input int w, input int h, input int nb, input int r);
      logic [31:0] v;
      v = {w[15:0], h[15:0]};
      push(DW'(4'hF), 1'b1, nb == 0, r, 1'b0);
      for (int k = 0; k < nb; k++)
         push(DW'(v[31-4*k -: 4]), 1'b0, k == nb-1, r, 1'b0);
      drive_beat(DW'(4'hF), 1'b1, nb == 0);
      for (int k = 0; k < nb; k++)
         drive_beat(DW'(v[31-4*k -: 4]), 1'b0, k == nb-1);
      if (nb >= 8 && w != 0 && h != 0) begin
         m_dv = 1'b1;
         m_tot = w * h;
      end
   endtask

   task automatic send_img(input int n, input int base, input int r);
      if (!m_dv) begin
         push('0, 1'b1, n == 0, r, 1'b0);
         for (int i = 0; i < n; i++) push(DW'(base + i), 1'b0, i == n-1, r, 1'b0);
      end else begin
         push('0, 1'b1, 1'b0, r, 1'b0);
         for (int i = 0; i < n && i < m_tot; i++)
            push(DW'(base + i), 1'b0, i == m_tot-1, r, 1'b0);
         for (int i = n; i < m_tot; i++) push(FILL, 1'b0, i == m_tot-1, r, 1'b1);
         if (n < m_tot) m_pad++;
         if (n > m_tot) m_trunc++;
      end
      drive_beat('0, 1'b1, n == 0);
      for (int i = 0; i < n; i++) drive_beat(DW'(base + i), 1'b0, i == n-1);
   endtask

   task automatic send_other(input logic [3:0] kind, input int n, input int r);
      push(DW'(kind), 1'b1, n == 0, r, 1'b0);
      for (int i = 0; i < n; i++) push(DW'(24'h5A0000 + i), 1'b0, i == n-1, r, 1'b0);
      drive_beat(DW'(kind), 1'b1, n == 0);
      for (int i = 0; i < n; i++) drive_beat(DW'(24'h5A0000 + i), 1'b0, i == n-1);
   endtask

   task automatic drain(input string req);
      int k;
      k = 0;
      while (sb.size() != 0 && k < 3000) begin
         @(negedge clk);
         k++;
      end
      repeat (4) @(negedge clk);
      chk(req, sb.size(), 0);
   endtask

   task automatic check_stats(input string req);
      chk({req, " pad_count"}, int'(pad_count), m_pad);
      chk({req, " trunc_count"}, int'(trunc_count), m_trunc);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #(CLK_PERIOD/4);
      // R1: reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 in_ready", int'(in_ready), 1);
      chk("R1 pad_count", int'(pad_count), 0);
      chk("R1 trunc_count", int'(trunc_count), 0);
      @(negedge clk);

      // R3: no dimensions yet, short and long images untouched
      send_img(5, 24'h000100, 3);
      send_img(0, 24'h000200, 3);
      drain("R3");
      // R8: truncated control packet does not establish dimensions
      send_ctrl(3, 2, 4, 8);
      send_img(3, 24'h000300, 8);
      drain("R8");
      check_stats("R3");

      // R2 / R4: 3x2 frame, exact length
      send_ctrl(3, 2, 8, 2);
      send_img(6, 24'h001000, 4);
      drain("R4");
      check_stats("R4");

      // R5: short image padded
      send_img(4, 24'h002000, 5);
      drain("R5");
      check_stats("R10 pad");

      // R6: long image truncated, next packet still aligned
      send_img(9, 24'h003000, 6);
      send_img(6, 24'h003100, 6);
      drain("R6");
      check_stats("R10 trunc");

      // R7: latest control packet wins
      send_ctrl(2, 2, 8, 7);
      send_ctrl(4, 3, 8, 7);
      send_img(12, 24'h004000, 7);
      send_img(10, 24'h004100, 7);
      drain("R7");

      // R9: unknown packet kind passes, counters unchanged
      send_other(4'h3, 4, 9);
      send_other(4'h7, 0, 9);
      drain("R9");
      check_stats("R9");

      // R12: header-only image padded to whole frame
      send_img(0, 24'h005000, 12);
      drain("R12");
      check_stats("R12");

      // R8: zero width ignored, 4x3 stays
      send_ctrl(0, 5, 8, 8);
      send_img(12, 24'h006000, 8);
      drain("R8 zero");
      check_stats("R8");

      // R11: random downstream stalls
      bp_on = 1'b1;
      send_img(7, 24'h007000, 11);
      send_img(15, 24'h007100, 11);
      send_ctrl(5, 1, 8, 11);
      send_img(5, 24'h007200, 11);
      send_img(1, 24'h007300, 11);
      send_img(0, 24'h007400, 11);
      drain("R11");
      check_stats("R11");
      bp_on = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule